// File: doc/BRIEF.md
# JTAG TAP with user-instruction data-register port

This block is a complete IEEE 1149.1 test access port controller built for one job: handing a single user-defined data-register scan over to internal logic. It runs the sixteen-state TAP machine on TCK. It keeps a 6-bit instruction register and a one-bit bypass register. It tells user logic, through per-state strobes, when the scan chain is working on its instruction. The instance is set up to answer one of four USER instruction slots.

When the instruction register holds the configured USER opcode, a sticky select output is high. Capture, shift and update strobes then follow the matching data-register states. A gated data clock pulses with TCK only during CAPTURE-DR and SHIFT-DR, and the serial output carries the bit supplied by user logic. Any other opcode routes the data-register path through the bypass bit. TCK, TDI and TMS are also passed straight through for logic that decodes the scan stream itself.

Top module: `jtag_user_tap`

## Requirements
- R1: The TAP state moves on each rising edge of TCK along the standard 16-state graph. reset_o is high exactly in TEST-LOGIC-RESET and runtest_o exactly in RUN-TEST/IDLE.
- R2: Five consecutive rising TCK edges with TMS high reach TEST-LOGIC-RESET from any state. At the next falling edge there, the instruction register holds BYPASS (6'h3f) and sel_o is low.
- R3: While rst_ni is low, the TAP is held asynchronously in TEST-LOGIC-RESET with BYPASS loaded, and tdo_o, tdo_oe_o and drck_o are low.
- R4: CAPTURE-IR loads 6'b000001 into the instruction shifter. Each rising edge in SHIFT-IR shifts tdi_i into bit 5 and moves the shifter right, and bit 0 is presented on tdo_o. The shifted value becomes the active instruction at the falling edge of TCK in UPDATE-IR.
- R5: sel_o is high exactly when the active instruction equals the opcode of the configured slot, which is 6'h02 for slot 1, the default. It changes only at a falling edge in UPDATE-IR or TEST-LOGIC-RESET.
- R6: capture_o, shift_o and update_o equal sel_o ANDed with the TAP being in CAPTURE-DR, SHIFT-DR and UPDATE-DR respectively.
- R7: drck_o is low during the low phase of TCK. During a high phase it equals TCK exactly when the preceding falling edge found sel_o high and the TAP in CAPTURE-DR or SHIFT-DR.
- R8: tck_o, tdi_o and tms_o are combinational copies of tck_i, tdi_i and tms_i.
- R9: With sel_o high, the falling edge in SHIFT-DR loads user_tdo_i onto tdo_o.
- R10: With sel_o low, the data path is a single bypass bit. It is cleared in CAPTURE-DR and loaded from tdi_i at each rising edge in SHIFT-DR, and it is shown on tdo_o at the falling edge. This covers BYPASS, unknown codes such as 6'h15, and the opcodes of the other slots.
- R11: tdo_oe_o is high, and tdo_o may be non-zero, only for TCK periods whose falling edge occurred in SHIFT-IR or SHIFT-DR. Otherwise both are low.
- R12: USER_SLOT is restricted to 1 to 4, and the slots map to the opcodes 6'h02, 6'h03, 6'h22 and 6'h23. An instance never selects on another slot's opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Serial test data in |
| rst_ni | input | 1 | Asynchronous active-low TAP reset (TRST) |
| user_tdo_i | input | 1 | Serial data from user logic for the selected DR |
| tdo_o | output | 1 | Serial test data out, falling-edge timed |
| tdo_oe_o | output | 1 | Output enable for tdo_o |
| sel_o | output | 1 | Configured USER instruction is active |
| capture_o | output | 1 | CAPTURE-DR with select |
| shift_o | output | 1 | SHIFT-DR with select |
| update_o | output | 1 | UPDATE-DR with select |
| reset_o | output | 1 | TAP in TEST-LOGIC-RESET |
| runtest_o | output | 1 | TAP in RUN-TEST/IDLE |
| drck_o | output | 1 | Gated DR clock |
| tck_o | output | 1 | Copy of tck_i |
| tdi_o | output | 1 | Copy of tdi_i |
| tms_o | output | 1 | Copy of tms_i |

## Verification
The hardest situations to reach are the transitions through the pause states and the TMS-high escape from deep inside a DR or IR scan. Both need precise TMS sequences, and the escape must happen while select is held. The bench uses scripted scans with Exit2/Pause loops on both the IR and DR sides. It loads the user opcode and then abandons a SHIFT-DR scan with five TMS-high cycles. It also runs a long biased random TMS walk against the reference model so that every state and edge pair is visited. The other slots' opcodes and an unknown opcode are loaded explicitly, and the bench checks that they fall through to the bypass bit.

// File: rtl/jtag_user_pkg.sv
package jtag_user_pkg;
  typedef enum logic [3:0] {
    TAP_EX2_DR  = 4'h0,
    TAP_EX1_DR  = 4'h1,
    TAP_SH_DR   = 4'h2,
    TAP_PAU_DR  = 4'h3,
    TAP_SEL_IR  = 4'h4,
    TAP_UPD_DR  = 4'h5,
    TAP_CAP_DR  = 4'h6,
    TAP_SEL_DR  = 4'h7,
    TAP_EX2_IR  = 4'h8,
    TAP_EX1_IR  = 4'h9,
    TAP_SH_IR   = 4'hA,
    TAP_PAU_IR  = 4'hB,
    TAP_IDLE    = 4'hC,
    TAP_UPD_IR  = 4'hD,
    TAP_CAP_IR  = 4'hE,
    TAP_RESET   = 4'hF
  } tap_state_e;
endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_user_pkg::*;
#(
  parameter int unsigned RESET_RUN = 5
) (
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  localparam int unsigned CW = $clog2(RESET_RUN + 1);

  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TAP_RESET:  state_d = tms_i ? TAP_RESET  : TAP_IDLE;
      TAP_IDLE:   state_d = tms_i ? TAP_SEL_DR : TAP_IDLE;
      TAP_SEL_DR: state_d = tms_i ? TAP_SEL_IR : TAP_CAP_DR;
      TAP_CAP_DR: state_d = tms_i ? TAP_EX1_DR : TAP_SH_DR;
      TAP_SH_DR:  state_d = tms_i ? TAP_EX1_DR : TAP_SH_DR;
      TAP_EX1_DR: state_d = tms_i ? TAP_UPD_DR : TAP_PAU_DR;
      TAP_PAU_DR: state_d = tms_i ? TAP_EX2_DR : TAP_PAU_DR;
      TAP_EX2_DR: state_d = tms_i ? TAP_UPD_DR : TAP_SH_DR;
      TAP_UPD_DR: state_d = tms_i ? TAP_SEL_DR : TAP_IDLE;
      TAP_SEL_IR: state_d = tms_i ? TAP_RESET  : TAP_CAP_IR;
      TAP_CAP_IR: state_d = tms_i ? TAP_EX1_IR : TAP_SH_IR;
      TAP_SH_IR:  state_d = tms_i ? TAP_EX1_IR : TAP_SH_IR;
      TAP_EX1_IR: state_d = tms_i ? TAP_UPD_IR : TAP_PAU_IR;
      TAP_PAU_IR: state_d = tms_i ? TAP_EX2_IR : TAP_PAU_IR;
      TAP_EX2_IR: state_d = tms_i ? TAP_UPD_IR : TAP_SH_IR;
      TAP_UPD_IR: state_d = tms_i ? TAP_SEL_DR : TAP_IDLE;
      default:    state_d = TAP_RESET;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TAP_RESET;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // checker-side run counter of consecutive TMS-high edges
  logic [CW-1:0] tms_run_q;
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                             tms_run_q <= '0;
    else if (!tms_i)                         tms_run_q <= '0;
    else if (tms_run_q != CW'(RESET_RUN))    tms_run_q <= tms_run_q + 1'b1;
  end

  a_r2_tms_escape: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (tms_run_q == CW'(RESET_RUN)) |-> (state_q == TAP_RESET));

  a_r1_idle_entry: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == TAP_IDLE) |-> $past(!tms_i));
endmodule

// File: rtl/jtag_ir.sv
module jtag_ir
  import jtag_user_pkg::*;
#(
  parameter int unsigned IR_W      = 6,
  parameter int unsigned USER_SLOT = 1
) (
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tdi_i,
  input  tap_state_e state_i,
  output logic       ir_lsb_o,
  output logic       sel_o
);
  localparam logic [IR_W-1:0] IR_BYPASS  = {IR_W{1'b1}};
  localparam logic [IR_W-1:0] IR_CAPTURE = IR_W'(1);
  localparam logic [IR_W-1:0] USER_OP =
      ((USER_SLOT >= 3) ? (IR_W'(1) << (IR_W - 1)) : '0) |
      IR_W'(2) | ((USER_SLOT % 2 == 0) ? IR_W'(1) : '0);

  generate
    if (USER_SLOT < 1 || USER_SLOT > 4) begin : g_bad_slot
      $error("USER_SLOT must be 1..4");
    end
    if (IR_W < 6) begin : g_bad_width
      $error("IR_W must be at least 6");
    end
  endgenerate

  logic [IR_W-1:0] ir_sr_q, ir_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) ir_sr_q <= '0;
    else if (state_i == TAP_CAP_IR) ir_sr_q <= IR_CAPTURE;
    else if (state_i == TAP_SH_IR)  ir_sr_q <= {tdi_i, ir_sr_q[IR_W-1:1]};
  end

  // active instruction changes on the falling edge only
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) ir_q <= IR_BYPASS;
    else if (state_i == TAP_RESET)  ir_q <= IR_BYPASS;
    else if (state_i == TAP_UPD_IR) ir_q <= ir_sr_q;
  end

  assign ir_lsb_o = ir_sr_q[0];
  assign sel_o    = (ir_q == USER_OP);

  a_r2_reset_clears_sel: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == TAP_RESET) |-> !sel_o);

  a_r5_sel_sticky: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i != TAP_UPD_IR && state_i != TAP_RESET) |-> $stable(sel_o));

  a_r4_capture_pattern: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $past(state_i == TAP_CAP_IR) |-> (ir_sr_q[1:0] == 2'b01));
endmodule

// File: rtl/jtag_dr_tdo.sv
module jtag_dr_tdo
  import jtag_user_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tdi_i,
  input  tap_state_e state_i,
  input  logic       sel_i,
  input  logic       ir_lsb_i,
  input  logic       user_tdo_i,
  output logic       tdo_o,
  output logic       tdo_oe_o,
  output logic       drck_o
);
  logic byp_q, tdo_q, oe_q, clk_en_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) byp_q <= 1'b0;
    else if (state_i == TAP_CAP_DR) byp_q <= 1'b0;
    else if (state_i == TAP_SH_DR)  byp_q <= tdi_i;
  end

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q    <= 1'b0;
      oe_q     <= 1'b0;
      clk_en_q <= 1'b0;
    end else begin
      oe_q     <= (state_i == TAP_SH_IR) || (state_i == TAP_SH_DR);
      clk_en_q <= sel_i && ((state_i == TAP_CAP_DR) || (state_i == TAP_SH_DR));
      if (state_i == TAP_SH_IR)      tdo_q <= ir_lsb_i;
      else if (state_i == TAP_SH_DR) tdo_q <= sel_i ? user_tdo_i : byp_q;
      else                           tdo_q <= 1'b0;
    end
  end

  // enable latched on the low phase: glitch-free gate
  assign drck_o   = tck_i & clk_en_q;
  assign tdo_o    = tdo_q;
  assign tdo_oe_o = oe_q;

  a_r11_oe_only_in_shift: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_oe_o |-> (state_i == TAP_SH_IR || state_i == TAP_SH_DR));

  a_r11_tdo_quiet: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !tdo_oe_o |-> !tdo_o);

  a_r10_bypass_cleared: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $past(state_i == TAP_CAP_DR) |-> !byp_q);
endmodule

// File: rtl/jtag_user_tap.sv
module jtag_user_tap
  import jtag_user_pkg::*;
#(
  parameter int unsigned USER_SLOT = 1,
  parameter int unsigned IR_W      = 6,
  parameter int unsigned RESET_RUN = 5
) (
  input  logic tck_i,
  input  logic tms_i,
  input  logic tdi_i,
  input  logic rst_ni,
  input  logic user_tdo_i,
  output logic tdo_o,
  output logic tdo_oe_o,
  output logic sel_o,
  output logic capture_o,
  output logic shift_o,
  output logic update_o,
  output logic reset_o,
  output logic runtest_o,
  output logic drck_o,
  output logic tck_o,
  output logic tdi_o,
  output logic tms_o
);
  tap_state_e state;
  logic       sel, ir_lsb;

  jtag_tap_fsm #(.RESET_RUN(RESET_RUN)) u_fsm (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .tms_i   (tms_i),
    .state_o (state)
  );

  jtag_ir #(.IR_W(IR_W), .USER_SLOT(USER_SLOT)) u_ir (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .tdi_i    (tdi_i),
    .state_i  (state),
    .ir_lsb_o (ir_lsb),
    .sel_o    (sel)
  );

  jtag_dr_tdo u_dr (
    .tck_i      (tck_i),
    .rst_ni     (rst_ni),
    .tdi_i      (tdi_i),
    .state_i    (state),
    .sel_i      (sel),
    .ir_lsb_i   (ir_lsb),
    .user_tdo_i (user_tdo_i),
    .tdo_o      (tdo_o),
    .tdo_oe_o   (tdo_oe_o),
    .drck_o     (drck_o)
  );

  assign sel_o     = sel;
  assign capture_o = sel && (state == TAP_CAP_DR);
  assign shift_o   = sel && (state == TAP_SH_DR);
  assign update_o  = sel && (state == TAP_UPD_DR);
  assign reset_o   = (state == TAP_RESET);
  assign runtest_o = (state == TAP_IDLE);
  assign tck_o     = tck_i;
  assign tdi_o     = tdi_i;
  assign tms_o     = tms_i;

  a_r6_strobes_exclusive: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $onehot0({capture_o, shift_o, update_o, reset_o, runtest_o}));

  a_r6_update_follows_scan: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $rose(update_o) |-> $past(state == TAP_EX1_DR || state == TAP_EX2_DR));
endmodule

// File: tb/sim_jtag_user_tap.sv
module sim_jtag_user_tap;
  // own state numbering for the reference model
  localparam int S_TLR = 0, S_RTI = 1, S_SDR = 2, S_CDR = 3, S_SHDR = 4,
                 S_E1DR = 5, S_PDR = 6, S_E2DR = 7, S_UDR = 8, S_SIR = 9,
                 S_CIR = 10, S_SHIR = 11, S_E1IR = 12, S_PIR = 13,
                 S_E2IR = 14, S_UIR = 15;
  localparam logic [5:0] OPC = 6'h02;

  logic tck = 1'b0, tms_r = 1'b0, tdi_r = 1'b0, rst_n = 1'b0, utdo_r = 1'b0;
  logic tdo, tdo_oe, sel, cap, shf, upd, rst_st, rti, drck, tck_c, tdi_c, tms_c;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  int         m_st;
  logic [5:0] m_irsr, m_ir;
  logic       m_byp, m_tdo, m_oe, m_en;
  string      tdo_req = "R11";

  always #10 tck = ~tck;

  jtag_user_tap u0 (
    .tck_i(tck), .tms_i(tms_r), .tdi_i(tdi_r), .rst_ni(rst_n),
    .user_tdo_i(utdo_r), .tdo_o(tdo), .tdo_oe_o(tdo_oe), .sel_o(sel),
    .capture_o(cap), .shift_o(shf), .update_o(upd), .reset_o(rst_st),
    .runtest_o(rti), .drck_o(drck), .tck_o(tck_c), .tdi_o(tdi_c), .tms_o(tms_c)
  );

  function automatic int nxt(int s, logic t);
    case (s)
      S_TLR:  return t ? S_TLR  : S_RTI;
      S_RTI:  return t ? S_SDR  : S_RTI;
      S_SDR:  return t ? S_SIR  : S_CDR;
      S_CDR:  return t ? S_E1DR : S_SHDR;
      S_SHDR: return t ? S_E1DR : S_SHDR;
      S_E1DR: return t ? S_UDR  : S_PDR;
      S_PDR:  return t ? S_E2DR : S_PDR;
      S_E2DR: return t ? S_UDR  : S_SHDR;
      S_UDR:  return t ? S_SDR  : S_RTI;
      S_SIR:  return t ? S_TLR  : S_CIR;
      S_CIR:  return t ? S_E1IR : S_SHIR;
      S_SHIR: return t ? S_E1IR : S_SHIR;
      S_E1IR: return t ? S_UIR  : S_PIR;
      S_PIR:  return t ? S_E2IR : S_PIR;
      S_E2IR: return t ? S_UIR  : S_SHIR;
      default: return t ? S_SDR : S_RTI;
    endcase
  endfunction

  task automatic model_reset();
    m_st = S_TLR; m_irsr = '0; m_ir = 6'h3f; m_byp = 0; m_tdo = 0; m_oe = 0; m_en = 0;
    tdo_req = "R3";
  endtask

  task automatic model_rise();
    if (m_st == S_CIR)       m_irsr = 6'b000001;
    else if (m_st == S_SHIR) m_irsr = {tdi_r, m_irsr[5:1]};
    if (m_st == S_CDR)       m_byp = 0;
    else if (m_st == S_SHDR) m_byp = tdi_r;
    m_st = nxt(m_st, tms_r);
  endtask

  task automatic model_fall();
    logic s;
    s = (m_ir == OPC);
    m_oe = (m_st == S_SHIR) || (m_st == S_SHDR);
    m_en = s && ((m_st == S_CDR) || (m_st == S_SHDR));
    if (m_st == S_SHIR)      begin m_tdo = m_irsr[0]; tdo_req = "R4"; end
    else if (m_st == S_SHDR) begin m_tdo = s ? utdo_r : m_byp; tdo_req = s ? "R9" : "R10"; end
    else                     begin m_tdo = 0; tdo_req = "R11"; end
    if (m_st == S_TLR)      m_ir = 6'h3f;
    else if (m_st == S_UIR) m_ir = m_irsr;
  endtask

  task automatic chk(string req, string nm, logic act, logic exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, nm, $time, act, exp);
    end
  endtask

  task automatic compare(logic hi);
    logic s;
    s = (m_ir == OPC);
    vectors++;
    chk("R5", "sel_o", sel, s);
    chk("R6", "capture_o", cap, s && m_st == S_CDR);
    chk("R6", "shift_o", shf, s && m_st == S_SHDR);
    chk("R6", "update_o", upd, s && m_st == S_UDR);
    chk("R1", "reset_o", rst_st, m_st == S_TLR);
    chk("R1", "runtest_o", rti, m_st == S_RTI);
    chk("R7", "drck_o", drck, hi & m_en);
    chk("R8", "tck_o", tck_c, hi);
    chk("R8", "tdi_o", tdi_c, tdi_r);
    chk("R8", "tms_o", tms_c, tms_r);
    chk(tdo_req, "tdo_o", tdo, m_tdo);
    chk("R11", "tdo_oe_o", tdo_oe, m_oe);
  endtask

  task automatic step(logic t, logic d);
    tms_r = t; tdi_r = d; utdo_r = 1'($urandom);
    @(posedge tck); model_rise(); #5 compare(1'b1);
    @(negedge tck); model_fall(); #5 compare(1'b0);
  endtask

  task automatic to_idle();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic load_ir(logic [5:0] op);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 6; i++) step(i == 5, op[i]);
    step(1, 0); step(0, 0);
  endtask

  task automatic dr_scan(int n);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) step(i == n - 1, 1'($urandom));
    step(1, 0); step(0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    @(negedge tck); #5 compare(1'b0);  // R3 reset state
    rst_n = 1'b1;
    step(0, 0); step(0, 0);             // R1 into idle
    // R4 R5: select the user slot, then R9 R7 R6 data scan
    load_ir(OPC);
    dr_scan(12);
    // DR pause/exit2 loop with select held (R5 sticky)
    step(1, 0); step(0, 0); step(0, 1); step(0, 0);
    step(1, 1); step(0, 0); step(0, 0); step(1, 0); step(0, 1); step(0, 0);
    step(1, 0); step(0, 0); step(1, 0); step(1, 0); step(0, 0);
    // R12 R10: other slots' opcodes, BYPASS and an unknown code use bypass
    load_ir(6'h03); dr_scan(8);
    load_ir(6'h22); dr_scan(8);
    load_ir(6'h23); dr_scan(8);
    load_ir(6'h3f); dr_scan(9);
    load_ir(6'h15); dr_scan(9);
    // R4 IR pause/exit2 path, landing on the user opcode
    step(1, 0); step(1, 0); step(0, 0); step(0, 1); step(0, 0);
    step(1, 0); step(0, 0); step(0, 0); step(1, 0); step(0, 0);
    for (int i = 0; i < 6; i++) step(i == 5, OPC[i]);
    step(1, 0); step(0, 0);
    // R2: abandon a DR shift with five TMS-high edges
    step(1, 0); step(0, 0); step(0, 1); step(0, 0);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1);
    step(0, 0);
    // R2 from select-IR: single TMS-high reaches reset
    load_ir(OPC);
    step(1, 0); step(1, 0); step(1, 0); step(0, 0);
    // R3: async reset in the middle of a selected DR shift
    load_ir(OPC);
    step(1, 0); step(0, 0); step(0, 1); step(0, 0);
    rst_n = 1'b0; model_reset(); #2 compare(1'b0);
    #1 rst_n = 1'b1;
    step(0, 0);
    // R1: biased random walk through the whole graph
    load_ir(OPC);
    for (int i = 0; i < 600; i++) step(($urandom % 3) == 0, 1'($urandom));
    to_idle();
    finish_run();
  end
endmodule